// File: doc/BRIEF.md
# Side-Effect Register Slave

This block is a memory-mapped register slave with a 32-bit data path and a fixed register map. A host issues single-cycle read or write strobes with a word-aligned byte address. The slave never stalls the bus. Write data is taken in the cycle of the strobe. Read data returns one cycle later, flagged by a read-valid output.

Some registers have side effects on access:
- A write to the launch register raises a one-cycle valid on an outgoing flow. The flow payload always follows the low bits of the write-data bus.
- A read of the pop register returns the state of an incoming valid/ready stream. In that same cycle it raises the stream's ready.
- A read of the event register returns the sticky bits gathered so far. It then restarts the accumulation from the current event inputs.
- A 64-bit value is spread over two consecutive words. Each word is read and written separately.

Register map (byte addresses, one word every 4 units):
- 0x00: control, read/write, 32 bits.
- 0x04: launch, write-only. It reads as zero.
- 0x08: pop. Stream valid is at bit 31 and payload at bits [PAY_W-1:0].
- 0x0C: event accumulator, at bits [EVT_W-1:0].
- 0x10: wide value, bits [31:0].
- 0x14: wide value, bits [63:32].

The read response is sequenced by a two-state machine:
- RSP_IDLE: no response is due.
- RSP_SEND: a response is on the bus.
- A read strobe moves the machine to RSP_SEND, from either state.
- A cycle without a read strobe returns it to RSP_IDLE.

Top module: `regslv_top`

## Requirements
- R1: A write to 0x00 stores all 32 bits of write data, visible on `ctrl_out` after the clock edge. A later read of 0x00 returns them.
- R2: `bus_rvalid` is high exactly in the cycle after a cycle with `bus_rd` high, and low in every other cycle.
- R3: Read-response bits not mapped at the accessed address are zero. This covers the launch register at 0x04 and every address from 0x18 upward.
- R4: `flow_valid` is high only in a cycle with `bus_wr` high and address 0x04. `flow_data` equals `bus_wdata[PAY_W-1:0]` in every cycle.
- R5: A read of 0x08 returns `pop_valid` at bit 31 and `pop_data` at bits [PAY_W-1:0]. `pop_ready` is high only in a cycle with `bus_rd` high and address 0x08.
- R6: The event register ORs `evt_in` into itself on every clock. A read of 0x0C returns the value held before that edge, and the register then reloads with the `evt_in` of the read cycle.
- R7: Address 0x10 holds wide bits [31:0] and 0x14 holds bits [63:32]. A write updates only the addressed word, as seen on `wide_out`.
- R8: When read and write strobes hit the same cycle, both are serviced. The read returns the contents held before the write.
- R9: While reset is held, all registers are zero and `flow_valid`, `pop_ready` and `bus_rvalid` are low. After reset, every register reads zero.
- R10: A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W | Word-aligned byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 32 | Read response data |
| ctrl_out | output | 32 | Control register contents |
| flow_valid | output | 1 | Outgoing flow valid pulse |
| flow_data | output | PAY_W | Outgoing flow payload |
| pop_valid | input | 1 | Incoming stream valid |
| pop_data | input | PAY_W | Incoming stream payload |
| pop_ready | output | 1 | Incoming stream ready |
| evt_in | input | EVT_W | Event inputs to accumulate |
| wide_out | output | WIDE_W | Wide value contents |

## Verification
Results are due at three different times:
- The flow valid, the flow payload and the stream ready follow the strobes and address in the same cycle. The bench checks them one time unit after driving the inputs, before the clock edge.
- Register outputs and the event state change at the next rising edge.
- The read response and its valid appear one cycle after the strobe.

Every operation in the bench drives its inputs on a falling edge. The expected read word is computed from the model before the rising edge, and the model is updated at that edge. Response, register outputs and read-valid are then compared at the following falling edge.

// File: rtl/regslv_pkg.sv
package regslv_pkg;
    localparam int DW         = 32;
    localparam int WORD_STEP  = DW / 8;
    localparam int IDX_CTRL   = 0;
    localparam int IDX_LAUNCH = 1;
    localparam int IDX_POP    = 2;
    localparam int IDX_EVT    = 3;
    localparam int IDX_WIDE   = 4;
    localparam int POP_VALID_BIT = DW - 1;

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_SEND = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/regslv_decode.sv
module regslv_decode #(
    parameter int ADDR_W = 8,
    parameter int NREG   = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   hit
);
    import regslv_pkg::*;
    // one comparator per register slot; misaligned addresses match nothing
    for (genvar i = 0; i < NREG; i++) begin : g_slot
        assign hit[i] = (addr == ADDR_W'(i * WORD_STEP));
    end
endmodule

// File: rtl/regslv_evt_acc.sv
module regslv_evt_acc #(
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_in,
    input  logic             reload,
    output logic [EVT_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (reload)
            acc <= evt_in;          // keep events of the read cycle
        else
            acc <= acc | evt_in;
    end
endmodule

// File: rtl/regslv_wide.sv
module regslv_wide #(
    parameter int WIDE_W = 64,
    parameter int WORDS  = (WIDE_W + 31) / 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORDS-1:0]     wr_hit,
    input  logic [31:0]          wdata,
    output logic [WORDS*32-1:0]  words,
    output logic [WIDE_W-1:0]    value
);
    localparam int SPAN = WORDS * 32;

    function automatic logic [31:0] word_mask(input int idx);
        logic [31:0] m;
        for (int b = 0; b < 32; b++)
            m[b] = (idx * 32 + b) < WIDE_W;
        return m;
    endfunction

    logic [SPAN-1:0] store;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else begin
            for (int i = 0; i < WORDS; i++)
                if (wr_hit[i])
                    store[i*32 +: 32] <= wdata & word_mask(i);
        end
    end

    assign words = store;
    assign value = store[WIDE_W-1:0];
endmodule

// File: rtl/regslv_top.sv
module regslv_top #(
    parameter int ADDR_W = 8,
    parameter int PAY_W  = 16,
    parameter int EVT_W  = 8,
    parameter int WIDE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       ctrl_out,
    output logic              flow_valid,
    output logic [PAY_W-1:0]  flow_data,
    input  logic              pop_valid,
    input  logic [PAY_W-1:0]  pop_data,
    output logic              pop_ready,
    input  logic [EVT_W-1:0]  evt_in,
    output logic [WIDE_W-1:0] wide_out
);
    import regslv_pkg::*;

    localparam int WORDS = (WIDE_W + DW - 1) / DW;
    localparam int NREG  = IDX_WIDE + WORDS;

    logic [NREG-1:0]     hit;
    logic [EVT_W-1:0]    evt_acc;
    logic [WORDS*DW-1:0] wide_words;
    logic [31:0]         ctrl_q;
    logic [31:0]         rd_word;
    logic [31:0]         rdata_q;
    rsp_state_e          rsp_q, rsp_d;

    regslv_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    regslv_evt_acc #(.EVT_W(EVT_W)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_in (evt_in),
        .reload (bus_rd && hit[IDX_EVT]),
        .acc    (evt_acc)
    );

    regslv_wide #(.WIDE_W(WIDE_W), .WORDS(WORDS)) u_wide (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (hit[NREG-1:IDX_WIDE] & {WORDS{bus_wr}}),
        .wdata  (bus_wdata),
        .words  (wide_words),
        .value  (wide_out)
    );

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (bus_wr && hit[IDX_CTRL])
            ctrl_q <= bus_wdata;
    end

    // read word assembly; unmapped bits stay zero
    always_comb begin
        rd_word = '0;
        if (hit[IDX_CTRL])
            rd_word = ctrl_q;
        if (hit[IDX_POP]) begin
            rd_word[POP_VALID_BIT] = pop_valid;
            rd_word[PAY_W-1:0]     = pop_data;
        end
        if (hit[IDX_EVT])
            rd_word[EVT_W-1:0] = evt_acc;
        for (int i = 0; i < WORDS; i++)
            if (hit[IDX_WIDE + i])
                rd_word = wide_words[i*DW +: DW];
    end

    // response state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_q <= RSP_IDLE;
        else
            rsp_q <= rsp_d;
    end

    // response transitions
    always_comb begin
        rsp_d = RSP_IDLE;
        unique case (rsp_q)
            RSP_IDLE: rsp_d = bus_rd ? RSP_SEND : RSP_IDLE;
            RSP_SEND: rsp_d = bus_rd ? RSP_SEND : RSP_IDLE;
        endcase
    end

    // response data register
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= rd_word;
        else
            rdata_q <= '0;
    end

    // outputs
    always_comb begin
        bus_rvalid = (rsp_q == RSP_SEND);
        bus_rdata  = rdata_q;
        ctrl_out   = ctrl_q;
        flow_valid = bus_wr && hit[IDX_LAUNCH];
        flow_data  = bus_wdata[PAY_W-1:0];
        pop_ready  = bus_rd && hit[IDX_POP];
    end
endmodule

// File: rtl/regslv_checker.sv
module regslv_checker #(
    parameter int ADDR_W = 8,
    parameter int WIDE_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rvalid,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       ctrl_out,
    input logic              flow_valid,
    input logic              pop_ready,
    input logic [31:0]       wide_lo
);
    localparam int WORDS   = (WIDE_W + 31) / 32;
    localparam int MAP_END = (4 + WORDS) * 4;

    logic unmapped;
    assign unmapped = (bus_addr == ADDR_W'(4)) || (bus_addr[1:0] != 2'b00)
                      || (int'(bus_addr) >= MAP_END);

    p_rsp_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> (bus_rdata == 32'h0));
    p_flow_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flow_valid |-> (bus_wr && bus_addr == ADDR_W'(4)));
    p_pop_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ready |-> (bus_rd && bus_addr == ADDR_W'(8)));
    p_ctrl_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0)) |=> (ctrl_out == $past(bus_wdata)));
    p_wide_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(16)) |=> (wide_lo == $past(bus_wdata)));
endmodule

bind regslv_top regslv_checker #(.ADDR_W(ADDR_W), .WIDE_W(WIDE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .ctrl_out   (ctrl_out),
    .flow_valid (flow_valid),
    .pop_ready  (pop_ready),
    .wide_lo    (wide_out[31:0])
);

// File: tb/regslv_top_test.sv
module regslv_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [31:0] ctrl_out;
    logic        flow_valid;
    logic [15:0] flow_data;
    logic        pop_valid = 1'b0;
    logic [15:0] pop_data = '0;
    logic        pop_ready;
    logic [7:0]  evt_in = '0;
    logic [63:0] wide_out;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_ctrl = '0;
    logic [63:0] m_wide = '0;
    logic [7:0]  m_evt = '0;
    logic        src_valid = 1'b0;
    logic [15:0] src_data = '0;
    logic [7:0]  evt_drive = '0;

    regslv_top uut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .ctrl_out(ctrl_out), .flow_valid(flow_valid),
        .flow_data(flow_data), .pop_valid(pop_valid), .pop_data(pop_data),
        .pop_ready(pop_ready), .evt_in(evt_in), .wide_out(wide_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tg, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tg, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return m_ctrl;
            8'h08: return {src_valid, 15'h0, src_data};
            8'h0C: return {24'h0, m_evt};
            8'h10: return m_wide[31:0];
            8'h14: return m_wide[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [7:0] a, input bit rd, input bit wr);
        if (rd && wr) return "R8";
        case (a)
            8'h00: return "R1";
            8'h08: return "R5";
            8'h0C: return "R6";
            8'h10, 8'h14: return "R7";
            default: return "R3";
        endcase
    endfunction

    task automatic bus_op(input bit rd, input bit wr, input logic [7:0] a, input logic [31:0] wd);
        logic [31:0] exp_rd;
        string tg;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        evt_in = evt_drive; pop_valid = src_valid; pop_data = src_data;
        #1;
        chk(flow_valid === (wr && a == 8'h04), "R4 flow_valid", 64'(flow_valid), 64'(wr && a == 8'h04));
        chk(flow_data === wd[15:0], "R4 flow_data", 64'(flow_data), 64'(wd[15:0]));
        chk(pop_ready === (rd && a == 8'h08), "R5 pop_ready", 64'(pop_ready), 64'(rd && a == 8'h08));
        exp_rd = exp_read(a);
        tg = tag_for(a, rd, wr);
        @(posedge clk);
        if (rd && a == 8'h0C) m_evt = evt_drive;
        else                  m_evt = m_evt | evt_drive;
        if (rd && a == 8'h08 && src_valid) begin
            src_data  = 16'($urandom);
            src_valid = 1'($urandom % 2);
        end
        if (wr) begin
            case (a)
                8'h00: m_ctrl = wd;
                8'h10: m_wide[31:0] = wd;
                8'h14: m_wide[63:32] = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        chk(bus_rvalid === rd, "R2 rvalid", 64'(bus_rvalid), 64'(rd));
        if (rd) chk(bus_rdata === exp_rd, tg, 64'(bus_rdata), 64'(exp_rd));
        chk(ctrl_out === m_ctrl, "R1 ctrl_out", 64'(ctrl_out), 64'(m_ctrl));
        chk(wide_out === m_wide, "R7 wide_out", wide_out, m_wide);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(bus_rvalid === 1'b0 && flow_valid === 1'b0 && pop_ready === 1'b0, "R9 outputs in reset",
            64'({bus_rvalid, flow_valid, pop_ready}), 64'h0);
        chk(ctrl_out === 32'h0 && wide_out === 64'h0, "R9 registers in reset", 64'(ctrl_out), 64'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) bus_op(1'b1, 1'b0, 8'(i * 4), 32'h0);  // R9 reads all zero

        // R1 control write/read
        bus_op(1'b0, 1'b1, 8'h00, 32'hA5A5_0F0F);
        bus_op(1'b1, 1'b0, 8'h00, 32'h0);
        // R8 read and write same cycle returns old value
        bus_op(1'b1, 1'b1, 8'h00, 32'h1234_5678);
        bus_op(1'b1, 1'b0, 8'h00, 32'h0);
        // R3 write-only launch reads zero, R4 pulse
        bus_op(1'b0, 1'b1, 8'h04, 32'hFFFF_BEEF);
        bus_op(1'b1, 1'b0, 8'h04, 32'hFFFF_FFFF);
        bus_op(1'b1, 1'b0, 8'h1C, 32'h0);
        // R10 write to unmapped address changes nothing
        bus_op(1'b0, 1'b1, 8'h18, 32'hDEAD_BEEF);
        bus_op(1'b0, 1'b1, 8'hFC, 32'hDEAD_BEEF);
        chk(ctrl_out === m_ctrl && wide_out === m_wide, "R10 unmapped write", 64'(ctrl_out), 64'(m_ctrl));
        // R6 sticky bits, read reload
        evt_drive = 8'h01; bus_op(1'b0, 1'b0, 8'h00, 32'h0);
        evt_drive = 8'h00; bus_op(1'b0, 1'b0, 8'h00, 32'h0);
        evt_drive = 8'h80; bus_op(1'b1, 1'b0, 8'h0C, 32'h0);   // returns 0x01
        evt_drive = 8'h00; bus_op(1'b1, 1'b0, 8'h0C, 32'h0);   // returns 0x80
        bus_op(1'b1, 1'b0, 8'h0C, 32'h0);                      // returns 0x00
        // R5 empty poll, then full pop
        src_valid = 1'b0; src_data = 16'h0000;
        bus_op(1'b1, 1'b0, 8'h08, 32'h0);
        src_valid = 1'b1; src_data = 16'hBEEF;
        bus_op(1'b1, 1'b0, 8'h08, 32'h0);
        // R7 one word at a time
        bus_op(1'b0, 1'b1, 8'h10, 32'h1111_2222);
        bus_op(1'b0, 1'b1, 8'h14, 32'h3333_4444);
        bus_op(1'b1, 1'b0, 8'h14, 32'h0);
        bus_op(1'b1, 1'b0, 8'h10, 32'h0);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            bit rd, wr;
            logic [7:0] a;
            int sel;
            sel = int'($urandom % 4);
            rd = (sel == 1) || (sel == 3);
            wr = (sel == 2) || (sel == 3);
            a = ($urandom % 16 == 0) ? 8'hF0 : 8'(($urandom % 8) * 4);
            evt_drive = ($urandom % 3 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            if (!src_valid && ($urandom % 4 == 0)) begin
                src_valid = 1'b1;
                src_data  = 16'($urandom);
            end
            bus_op(rd, wr, a, $urandom);
        end
        evt_drive = 8'h00;
        bus_op(1'b0, 1'b0, 8'h00, 32'h0);
        finish_run();
    end
endmodule